// File: doc/BRIEF.md
# I2C Multi-Message Transfer Sequencer

This block carries out a list of I2C messages without software involvement. It does so by driving the command, data and status registers of a separate byte-level I2C master. Each message is described by a 7-bit target address, a read flag, a no-start flag and a byte length. Bytes to send come from an external buffer, and received bytes are written into the same buffer. The buffer is addressed by message index and byte position.

A one-cycle `go` pulse with a message count launches a transfer. After each command, the sequencer waits for the byte master's interrupt. It reads the status register and works out the next step: a start with address, a byte write, a byte read, or a stop. Messages are chained either with a repeated start or with no start at all. Every transfer ends with a stop. The sequencer waits for the interrupt that follows the stop, acknowledges it, and only then reports `done` or `error`. A cycle-count watchdog ends a transfer that stalls and reports `timeout`.

The descriptor and buffer ports are combinational reads: the value must be valid in the same cycle as the index. The register bus also reads in the same cycle: `reg_rdata` must reflect `reg_addr` in the cycle that `reg_re` is high. Status and command share register address 4, and the data register is at address 3.

Top module: `i2c_msg_seq`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `error`, `timeout`, `reg_we`, `reg_re` and `buf_we` are all 0.
- R2: A `go` pulse with a non-zero count in idle writes the data register (address 3) with {address, read flag} two cycles later, then writes the command register (address 4) with 0x91 in the next cycle. Data always precedes its command, and there is at most one register access per clock.
- R3: Interrupts are taken on the rising edge. Each one causes a read of the status register (address 4). If status bit 5 (arbitration lost) is set, the sequencer writes command 0x41 (stop) and the transfer ends in error.
- R4: After an address or write byte, if status bit 7 (no acknowledge) is set, the sequencer writes 0x41 and the transfer ends in error.
- R5: In a read message, each interrupt causes a read of the data register (address 3). The byte is stored into the buffer at the current message and position, and the position advances. Each further byte is requested with 0x29 if it is the message's last byte, and with 0x21 otherwise.
- R6: In a write message, the next buffer byte is written to the data register, followed by command 0x11.
- R7: When a message's position reaches its length and messages remain, the sequencer moves on to the next message. If that message lacks the no-start flag, a new address byte and 0x91 are issued. If it has the flag, the transfer continues directly with reads or writes. The first message always starts.
- R8: After the last message, the sequencer writes 0x41. On the stop's interrupt it writes only 0x01 (interrupt acknowledge). In the following cycle it pulses `done` for a successful transfer, or `error` for a failed one.
- R9: If neither outcome is reached, `timeout` pulses exactly TIMEOUT_CYC cycles after the `go` cycle, and `busy` drops in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken only when idle |
| go_count | input | CNT_W | Number of messages in the list (1..MAX_MSGS) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: transfer completed |
| error | output | 1 | One-cycle pulse: transfer ended after NACK or arbitration loss |
| timeout | output | 1 | One-cycle pulse: watchdog expired |
| desc_idx | output | MIDX_W | Index of the current message (descriptor and buffer row) |
| desc_addr | input | 7 | Target address of message `desc_idx` |
| desc_rd | input | 1 | Message is a read |
| desc_nostart | input | 1 | Message continues without a new start |
| desc_len | input | LEN_W | Byte count of the message (at least 1) |
| buf_pos | output | LEN_W | Byte position within the current message |
| buf_we | output | 1 | Store a received byte |
| buf_wdata | output | 8 | Received byte |
| buf_rdata | input | 8 | Buffer byte at (`desc_idx`, `buf_pos`) |
| reg_we | output | 1 | Register write strobe to the byte master |
| reg_re | output | 1 | Register read strobe to the byte master |
| reg_addr | output | REG_AW | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid in the strobe cycle |
| irq | input | 1 | Byte master interrupt |

## Verification
The hardest cases to reach are the failure paths in the middle of a list: a NACK on a data byte several writes into a message, or arbitration loss partway through a read. These must still produce a stop, the stop's interrupt and the error pulse. The bench's byte-master model numbers every interrupt. It raises the NACK or arbitration flag in the status it returns for one chosen interrupt index, so any step of any message can fail on demand. Chaining without a start is covered by a three-message list that mixes reads and writes. The watchdog is covered by a master model that stops answering, followed by a normal transfer to show the block recovers.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   // protocol-level step of the transfer
   typedef enum logic [2:0] {
      XS_DONE,
      XS_START,
      XS_WRITE,
      XS_READ,
      XS_ERROR
   } xfer_st_e;

   // micro-phase of the register-bus sequencing
   typedef enum logic [3:0] {
      PH_IDLE,
      PH_NEXT,    // descriptor of msg_q is valid, decide start or continue
      PH_WDATA,   // write data register
      PH_WCMD,    // write command register
      PH_WAIT,    // wait for interrupt edge
      PH_STAT,    // read status register
      PH_RDATA,   // read data register into buffer
      PH_ADV,     // end-of-message test
      PH_ISSUE    // issue next read or write
   } phase_e;

   localparam logic [7:0] CMD_BEGIN   = 8'h91;
   localparam logic [7:0] CMD_END     = 8'h41;
   localparam logic [7:0] CMD_RD_ACK  = 8'h21;
   localparam logic [7:0] CMD_RD_NACK = 8'h29;
   localparam logic [7:0] CMD_WR      = 8'h11;
   localparam logic [7:0] CMD_CLR     = 8'h01;

   localparam int unsigned ST_NACK_BIT = 7;
   localparam int unsigned ST_ARB_BIT  = 5;

endpackage

// File: rtl/i2c_seq_irqedge.sv
module i2c_seq_irqedge #(
   parameter int unsigned SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_in,
   output logic rise
);
   logic lvl;
   logic prev_q;

   generate
      if (SYNC == 0) begin : g_direct
         assign lvl = irq_in;
      end else begin : g_sync
         localparam int unsigned SW = SYNC;
         logic [SW-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= (sh_q << 1) | SW'(irq_in);
         end
         assign lvl = sh_q[SW-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
   parameter int unsigned LIMIT = 1000,
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expire
);
   generate
      if (LIMIT == 0) begin : g_off
         assign expire = 1'b0;
      end else begin : g_on
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clear)            cnt_q <= '0;
            else if (run && !expire)   cnt_q <= cnt_q + CW'(1);
         end
         assign expire = run && (cnt_q == CW'(LIMIT - 1));

         // R9
         cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(LIMIT - 1));
      end
   endgenerate
endmodule

// File: rtl/i2c_seq_regport.sv
module i2c_seq_regport
   import i2c_seq_pkg::*;
#(
   parameter int unsigned    AW       = 3,
   parameter logic [AW-1:0]  DATA_REG = 3,
   parameter logic [AW-1:0]  CMD_REG  = 4
) (
   input  phase_e        phase,
   input  logic [7:0]    dat,
   input  logic [7:0]    cmd,
   output logic          we,
   output logic          re,
   output logic [AW-1:0] addr,
   output logic [7:0]    wdata
);
   always_comb begin
      we    = 1'b0;
      re    = 1'b0;
      addr  = CMD_REG;
      wdata = 8'h00;
      case (phase)
         PH_WDATA: begin we = 1'b1; addr = DATA_REG; wdata = dat; end
         PH_WCMD:  begin we = 1'b1; wdata = cmd; end
         PH_STAT:  re = 1'b1;
         PH_RDATA: begin re = 1'b1; addr = DATA_REG; end
         default:  ;
      endcase
   end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
   import i2c_seq_pkg::*;
#(
   parameter int unsigned        MAX_MSGS    = 4,
   parameter int unsigned        MAX_LEN     = 16,
   parameter int unsigned        TIMEOUT_CYC = 100_000_000,
   parameter int unsigned        IRQ_SYNC    = 2,
   parameter int unsigned        REG_AW      = 3,
   parameter logic [REG_AW-1:0]  DATA_REG    = 3,
   parameter logic [REG_AW-1:0]  CMD_REG     = 4,
   localparam int unsigned CNT_W  = $clog2(MAX_MSGS + 1),
   localparam int unsigned MIDX_W = (MAX_MSGS > 1) ? $clog2(MAX_MSGS) : 1,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CNT_W-1:0]  go_count,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic              timeout,
   output logic [MIDX_W-1:0] desc_idx,
   input  logic [6:0]        desc_addr,
   input  logic              desc_rd,
   input  logic              desc_nostart,
   input  logic [LEN_W-1:0]  desc_len,
   output logic [LEN_W-1:0]  buf_pos,
   output logic              buf_we,
   output logic [7:0]        buf_wdata,
   input  logic [7:0]        buf_rdata,
   output logic              reg_we,
   output logic              reg_re,
   output logic [REG_AW-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   input  logic [7:0]        reg_rdata,
   input  logic              irq
);
   initial begin
      assert (MAX_MSGS >= 1) else $error("MAX_MSGS must be at least 1");
      assert (MAX_LEN >= 1) else $error("MAX_LEN must be at least 1");
      assert (DATA_REG != CMD_REG) else $error("register addresses collide");
   end

   phase_e           phase_q;
   xfer_st_e         xst_q;
   logic [CNT_W-1:0] msg_q, cnt_q;
   logic [LEN_W-1:0] pos_q;
   logic [7:0]       dat_q, cmd_q;
   logic             fin_q, done_q, err_q, tmo_q;
   logic             irq_rise, expire, accept, last_msg;

   assign accept   = (phase_q == PH_IDLE) && go && (go_count != '0);
   assign last_msg = (msg_q + CNT_W'(1)) == cnt_q;
   assign busy     = (phase_q != PH_IDLE);

   i2c_seq_irqedge #(.SYNC(IRQ_SYNC)) u_edge (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .rise(irq_rise));

   i2c_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy), .expire(expire));

   i2c_seq_regport #(.AW(REG_AW), .DATA_REG(DATA_REG), .CMD_REG(CMD_REG)) u_port (
      .phase(phase_q), .dat(dat_q), .cmd(cmd_q),
      .we(reg_we), .re(reg_re), .addr(reg_addr), .wdata(reg_wdata));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         xst_q   <= XS_DONE;
         msg_q   <= '0;
         cnt_q   <= '0;
         pos_q   <= '0;
         dat_q   <= '0;
         cmd_q   <= '0;
         fin_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         tmo_q  <= 1'b0;
         if (expire) begin
            tmo_q   <= 1'b1;
            phase_q <= PH_IDLE;
         end else begin
            case (phase_q)
               PH_IDLE: if (accept) begin
                  cnt_q   <= go_count;
                  msg_q   <= '0;
                  pos_q   <= '0;
                  fin_q   <= 1'b0;
                  xst_q   <= XS_START;
                  phase_q <= PH_NEXT;
               end
               PH_NEXT: begin
                  if (desc_nostart && (msg_q != '0)) begin
                     xst_q   <= desc_rd ? XS_READ : XS_WRITE;
                     phase_q <= PH_ISSUE;
                  end else begin
                     xst_q   <= XS_START;
                     dat_q   <= {desc_addr, desc_rd};
                     cmd_q   <= CMD_BEGIN;
                     phase_q <= PH_WDATA;
                  end
               end
               PH_WDATA: phase_q <= PH_WCMD;
               PH_WCMD: begin
                  if (fin_q) begin
                     done_q  <= (xst_q == XS_DONE);
                     err_q   <= (xst_q == XS_ERROR);
                     phase_q <= PH_IDLE;
                  end else begin
                     phase_q <= PH_WAIT;
                  end
               end
               PH_WAIT: if (irq_rise) phase_q <= PH_STAT;
               PH_STAT: begin
                  if (xst_q == XS_DONE || xst_q == XS_ERROR) begin
                     cmd_q   <= CMD_CLR;
                     fin_q   <= 1'b1;
                     phase_q <= PH_WCMD;
                  end else if (reg_rdata[ST_ARB_BIT]) begin
                     xst_q   <= XS_ERROR;
                     cmd_q   <= CMD_END;
                     phase_q <= PH_WCMD;
                  end else if (xst_q == XS_START || xst_q == XS_WRITE) begin
                     if (reg_rdata[ST_NACK_BIT]) begin
                        xst_q   <= XS_ERROR;
                        cmd_q   <= CMD_END;
                        phase_q <= PH_WCMD;
                     end else begin
                        xst_q   <= desc_rd ? XS_READ : XS_WRITE;
                        phase_q <= PH_ADV;
                     end
                  end else begin
                     phase_q <= PH_RDATA;
                  end
               end
               PH_RDATA: begin
                  pos_q   <= pos_q + LEN_W'(1);
                  phase_q <= PH_ADV;
               end
               PH_ADV: begin
                  if (pos_q == desc_len) begin
                     if (last_msg) begin
                        xst_q   <= XS_DONE;
                        cmd_q   <= CMD_END;
                        phase_q <= PH_WCMD;
                     end else begin
                        msg_q   <= msg_q + CNT_W'(1);
                        pos_q   <= '0;
                        phase_q <= PH_NEXT;
                     end
                  end else begin
                     phase_q <= PH_ISSUE;
                  end
               end
               PH_ISSUE: begin
                  if (xst_q == XS_READ) begin
                     cmd_q   <= (pos_q == desc_len - LEN_W'(1)) ? CMD_RD_NACK : CMD_RD_ACK;
                     phase_q <= PH_WCMD;
                  end else begin
                     dat_q   <= buf_rdata;
                     pos_q   <= pos_q + LEN_W'(1);
                     cmd_q   <= CMD_WR;
                     phase_q <= PH_WDATA;
                  end
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign desc_idx  = msg_q[MIDX_W-1:0];
   assign buf_pos   = pos_q;
   assign buf_we    = (phase_q == PH_RDATA);
   assign buf_wdata = reg_rdata;
   assign done      = done_q;
   assign error     = err_q;
   assign timeout   = tmo_q;

   // R2
   data_then_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == DATA_REG) |=> (reg_we && reg_addr == CMD_REG));

   // R2
   single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !reg_re);

   // R2
   go_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy && go_count != '0) |=> ##1 (reg_we && reg_addr == DATA_REG));

   // R5
   store_after_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (reg_re && reg_addr == DATA_REG && $past(reg_re && reg_addr == CMD_REG)));

   // R8
   result_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> $past(reg_we && reg_addr == CMD_REG && reg_wdata == CMD_CLR));

   // R9
   timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (!busy && !done && !error));

endmodule

// File: tb/i2c_msg_seq_tb.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb_top;
   localparam int MM = 4, ML = 8, TMO = 3000;
   localparam int CW = 3, MW = 2, LW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          go = 1'b0;
   logic [CW-1:0] go_count = '0;
   logic          busy, done, error, timeout;
   logic [MW-1:0] desc_idx;
   logic [6:0]    desc_addr;
   logic          desc_rd, desc_nostart;
   logic [LW-1:0] desc_len, buf_pos;
   logic          buf_we;
   logic [7:0]    buf_wdata, buf_rdata;
   logic          reg_we, reg_re;
   logic [2:0]    reg_addr;
   logic [7:0]    reg_wdata, reg_rdata;
   logic          irq;

   logic [6:0]    d_addr [MM];
   logic          d_rd [MM];
   logic          d_ns [MM];
   logic [LW-1:0] d_len [MM];
   logic [7:0]    bmem [MM][ML];

   assign desc_addr    = d_addr[desc_idx];
   assign desc_rd      = d_rd[desc_idx];
   assign desc_nostart = d_ns[desc_idx];
   assign desc_len     = d_len[desc_idx];
   assign buf_rdata    = bmem[desc_idx][buf_pos[2:0]];

   i2c_msg_seq #(.MAX_MSGS(MM), .MAX_LEN(ML), .TIMEOUT_CYC(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .go(go), .go_count(go_count),
      .busy(busy), .done(done), .error(error), .timeout(timeout),
      .desc_idx(desc_idx), .desc_addr(desc_addr), .desc_rd(desc_rd),
      .desc_nostart(desc_nostart), .desc_len(desc_len),
      .buf_pos(buf_pos), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
      .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   int  errors = 0;
   int  checks = 0;
   bit  finished = 0;

   // ---------- byte-master model ----------
   int   ncmd = 0, cur_idx = -1, nack_at = -1, arb_at = -1, lat_cnt = 0, rx_n = 0;
   bit   hang = 0, rd_prev = 0;
   logic irq_r = 1'b0;
   logic [7:0] stat_v;
   assign irq = irq_r;
   always_comb stat_v = {(cur_idx == nack_at), 1'b0, (cur_idx == arb_at), 5'b0};
   assign reg_rdata = (reg_addr == 3'd4) ? stat_v : 8'(8'hC0 + rx_n);

   always @(negedge clk) begin
      if (rd_prev) rx_n++;
      rd_prev = reg_re && (reg_addr == 3'd3);
      irq_r = 1'b0;
      if (lat_cnt > 0) begin
         lat_cnt--;
         if (lat_cnt == 0) irq_r = 1'b1;
      end
      if (reg_we && reg_addr == 3'd4 && reg_wdata != 8'h01 && !hang) begin
         cur_idx = ncmd;
         ncmd++;
         lat_cnt = 5;
      end
      if (buf_we) bmem[desc_idx][buf_pos[2:0]] = buf_wdata;
   end

   // ---------- reference model queues ----------
   int    qa[$];
   int    qd[$];
   string qt[$];
   int    em[$];
   int    ep[$];
   int    ev[$];
   bit    exp_err;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic void push(input int a, input int d, input string t);
      qa.push_back(a); qd.push_back(d); qt.push_back(t);
   endfunction

   function automatic void build(input int n);
      int k, m, pos, st, rx;
      bit fin;
      k = 0; m = 0; pos = 0; st = 1; rx = 0; fin = 0;
      qa.delete(); qd.delete(); qt.delete(); em.delete(); ep.delete(); ev.delete();
      exp_err = 0;
      push(3, {d_addr[0], d_rd[0]}, "R2");
      push(4, 8'h91, "R2");
      for (int g = 0; g < 300 && !fin; g++) begin
         if (st == 0 || st == 4) begin
            push(4, 8'h01, "R8");
            exp_err = (st == 4);
            fin = 1;
         end else begin
            bit nk, ab, on;
            nk = (k == nack_at); ab = (k == arb_at); on = 1;
            k++;
            if (ab) begin
               st = 4; push(4, 8'h41, "R3"); on = 0;
            end else if (st == 1 || st == 2) begin
               if (nk) begin st = 4; push(4, 8'h41, "R4"); on = 0; end
               else st = d_rd[m] ? 3 : 2;
            end else begin
               em.push_back(m); ep.push_back(pos); ev.push_back((8'hC0 + rx) & 8'hFF);
               rx++; pos++;
            end
            if (on && pos == int'(d_len[m])) begin
               m++; pos = 0;
               if (m == n) begin st = 0; push(4, 8'h41, "R8"); on = 0; end
               else if (!d_ns[m]) begin
                  st = 1; push(3, {d_addr[m], d_rd[m]}, "R7"); push(4, 8'h91, "R7"); on = 0;
               end else st = d_rd[m] ? 3 : 2;
            end
            if (on) begin
               if (st == 3) push(4, (pos == int'(d_len[m]) - 1) ? 8'h29 : 8'h21, "R5");
               else begin push(3, bmem[m][pos], "R6"); push(4, 8'h11, "R6"); pos++; end
            end
         end
      end
   endfunction

   // ---------- per-clock comparison of register traffic ----------
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we && reg_re) chk(1'b0, "R2 one access", 2, 1);
         if (reg_we) begin
            if (qa.size() == 0) chk(1'b0, "R8 unexpected write", {reg_addr, reg_wdata}, 0);
            else begin
               int a, d;
               string t;
               a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
               chk(reg_addr == 3'(a) && reg_wdata == 8'(d), t,
                   {reg_addr, reg_wdata}, {a[2:0], d[7:0]});
            end
         end
      end
   end

   task automatic set_msg(input int i, input logic [6:0] a, input bit rd, input bit ns, input int len);
      d_addr[i] = a; d_rd[i] = rd; d_ns[i] = ns; d_len[i] = LW'(len);
      for (int j = 0; j < ML; j++) bmem[i][j] = rd ? 8'h00 : 8'((i << 4) + j + 1);
   endtask

   task automatic run(input int n, input string tag);
      int w;
      build(n);
      ncmd = 0; cur_idx = -1; rx_n = 0; lat_cnt = 0;
      @(negedge clk);
      go = 1'b1; go_count = CW'(n);
      @(negedge clk);
      go = 1'b0;
      w = 0;
      while (!(done || error || timeout) && w < 20000) begin
         @(negedge clk);
         w++;
      end
      chk(done == !exp_err && error == exp_err && !timeout, tag,
          {done, error, timeout}, {!exp_err, exp_err, 1'b0});
      chk(qa.size() == 0, "R8 all writes issued", qa.size(), 0);
      for (int i = 0; i < em.size(); i++)
         chk(bmem[em[i]][ep[i]] == 8'(ev[i]), "R5 stored byte", bmem[em[i]][ep[i]], ev[i]);
      repeat (3) @(negedge clk);
      chk(!busy, "R8 idle after result", busy, 0);
   endtask

   initial begin
      int n;
      for (int i = 0; i < MM; i++) set_msg(i, 7'h00, 1'b0, 1'b0, 1);
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !error && !timeout && !reg_we && !reg_re && !buf_we, "R1 in reset",
          {busy, done, error, timeout, reg_we, reg_re, buf_we}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !reg_we && !reg_re && !buf_we, "R1 after reset",
          {busy, reg_we, reg_re, buf_we}, 0);

      // R6 single write message
      set_msg(0, 7'h50, 0, 0, 3);
      run(1, "R6 write result");

      // R7 write then read with repeated start
      set_msg(0, 7'h3A, 0, 0, 2);
      set_msg(1, 7'h3A, 1, 0, 3);
      run(2, "R7 combined result");

      // R7 chaining without start, R5 read acks
      set_msg(0, 7'h21, 1, 0, 2);
      set_msg(1, 7'h21, 1, 1, 2);
      set_msg(2, 7'h21, 0, 1, 2);
      run(3, "R7 no-start result");

      // R4 address not acknowledged
      set_msg(0, 7'h11, 0, 0, 2);
      nack_at = 0;
      run(1, "R4 address nack result");

      // R4 data byte not acknowledged mid-message
      set_msg(0, 7'h12, 0, 0, 4);
      set_msg(1, 7'h12, 1, 0, 2);
      nack_at = 2;
      run(2, "R4 data nack result");
      nack_at = -1;

      // R3 arbitration lost during read
      set_msg(0, 7'h6C, 1, 0, 4);
      arb_at = 3;
      run(1, "R3 arb lost result");
      arb_at = -1;

      // R9 watchdog with silent master
      set_msg(0, 7'h40, 0, 0, 1);
      qa.delete(); qd.delete(); qt.delete();
      push(3, {7'h40, 1'b0}, "R9"); push(4, 8'h91, "R9");
      hang = 1;
      @(negedge clk);
      go = 1'b1; go_count = 3'd1;
      @(posedge clk);
      @(negedge clk);
      go = 1'b0;
      n = 0;
      while (!timeout && n < TMO + 100) begin
         @(negedge clk);
         n++;
      end
      chk(n == TMO, "R9 timeout cycle", n, TMO);
      chk(timeout && !busy && !done && !error, "R9 idle at timeout",
          {timeout, busy, done, error}, 4'b1000);
      hang = 0;
      repeat (10) @(negedge clk);

      // R9 recovery: normal transfer afterwards
      set_msg(0, 7'h50, 0, 0, 2);
      set_msg(1, 7'h50, 1, 0, 1);
      run(2, "R9 recovery result");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule